// File: doc/BRIEF.md
# Speculative Request Synchronizer with Rollback

This block takes a four-phase request/data handshake from an unrelated clock domain into a synchronous accumulator. The request passes through one capture flop only. The controller acts on that sample in the very next cycle, as if the flop had resolved cleanly. It adds the bundled data word into the accumulator and raises the acknowledge.

An external metastability detector (here an input, `meta_flag`) delivers a verdict on each sample a fixed `DEPTH` cycles later. Every state register (controller phase and accumulator) is shadowed by a `DEPTH`-level shift stack that takes in the current state every cycle. When a verdict flags a bad sample, the whole state is reloaded from the oldest stack entry, which is the state held just before that sample was consumed. The speculative acknowledge is withdrawn, and the still-held request is sampled and processed again. For `DEPTH` cycles after a rollback, further verdicts are ignored, because they describe samples whose effects were already thrown away.

Controller states: `PH_IDLE` (no transfer; on a sampled request high it takes the transition *accept*, which adds data and moves to `PH_HOLD`) and `PH_HOLD` (acknowledge high; on a sampled request low it takes the transition *release* back to `PH_IDLE`). Any state may take the transition *rewind* to the stacked phase. The verdict controller has the states `RB_ARMED` (it acts on a flag, taking the transition *rewind*) and `RB_BLIND` (it ignores flags for `DEPTH` cycles, then takes the transition *rearm*).

Top module: `specsync_rollback`

## Requirements
- R1: Reset forces `ack` low and `acc` to 0, and clears the capture flop and every history stack entry. A verdict taken on the first edge after reset therefore restores `acc` = 0, even if `acc` was nonzero before the reset.
- R2: The request is captured by a single flop. A request driven high before clock edge k is consumed at edge k+1: `ack` is still low after edge k and is high after edge k+1.
- R3: In `PH_IDLE`, a sampled request high adds `data_async` to `acc` and enters `PH_HOLD`, where `ack` = 1.
- R4: In `PH_HOLD`, `acc` does not change while the request stays high. A sample of request low returns the controller to `PH_IDLE`, so `ack` falls one edge after the low sample.
- R5: `meta_flag` sampled at edge t+DEPTH+1 is the verdict on the request sample captured at edge t. When it is high (and the controller is armed), `acc` and `ack` take back the values they had right after edge t.
- R6: After a rollback, the held request is sampled again and processed once. The final `acc` equals the sum, modulo 2^W, of one data word per completed handshake.
- R7: For the DEPTH edges following a rollback, `meta_flag` has no effect.
- R8: `acc` wraps modulo 2^W (200 + 100 gives 44 for W = 8).
- R9: A verdict raised while no handshake has changed state for more than DEPTH+1 cycles leaves `acc` and `ack` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the receiving domain |
| rst_n | input | 1 | Active-low synchronous reset |
| req_async | input | 1 | Four-phase request from the foreign domain |
| data_async | input | W | Bundled data, stable while the request is high |
| meta_flag | input | 1 | Detector verdict: the sample taken DEPTH+1 edges earlier was metastable |
| ack | output | 1 | Acknowledge, high in `PH_HOLD` |
| acc | output | W | Accumulator state |

## Verification
A request driven at a falling edge shows up as `ack` and the new `acc` after the second rising edge. The verdict on that sample must be driven so that it is sampled DEPTH+1 edges after the capture edge, and the restored values are visible right after that edge. Re-acceptance follows one edge later, and a low request clears `ack` two edges after it is driven. The bench drives and samples only at falling edges, and counts those exact edges before each check rather than polling, except when it waits for the acknowledge in random handshakes. Masked verdicts are placed where an unmasked one would restore a visibly different state.

// File: rtl/specsync_pkg.sv
package specsync_pkg;
    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_HOLD = 1'b1
    } phase_e;

    typedef enum logic [0:0] {
        RB_ARMED = 1'b0,
        RB_BLIND = 1'b1
    } rb_mode_e;
endpackage

// File: rtl/specsync_capture.sv
// Single capture flop for the foreign request; its output is used
// speculatively in the following cycle.
module specsync_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic samp_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) samp_q <= 1'b0;
        else        samp_q <= req_async;
    end
endmodule

// File: rtl/specsync_history.sv
// DEPTH-level shift stack of past state; the oldest entry is the state
// held just before the sample now being judged was consumed.
module specsync_history
    import specsync_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_e       cur_phase,
    input  logic [W-1:0] cur_acc,
    output phase_e       old_phase,
    output logic [W-1:0] old_acc
);
    localparam int LAST = DEPTH - 1;

    phase_e       ph_q [DEPTH];
    logic [W-1:0] ac_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ph_q[i] <= PH_IDLE;
                ac_q[i] <= '0;
            end
        end else begin
            ph_q[0] <= cur_phase;
            ac_q[0] <= cur_acc;
            for (int i = 1; i < DEPTH; i++) begin
                ph_q[i] <= ph_q[i-1];
                ac_q[i] <= ac_q[i-1];
            end
        end
    end

    assign old_phase = ph_q[LAST];
    assign old_acc   = ac_q[LAST];
endmodule

// File: rtl/specsync_verdict.sv
// Accepts detector verdicts, and blinds itself for DEPTH cycles after a rewind.
module specsync_verdict
    import specsync_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic meta_flag,
    output logic rollback
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] BLIND_LEN = CW'(DEPTH);

    rb_mode_e      mode_q, mode_nx;
    logic [CW-1:0] cnt_q, cnt_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RB_ARMED;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_nx;
            cnt_q  <= cnt_nx;
        end
    end

    always_comb begin
        mode_nx = mode_q;
        cnt_nx  = cnt_q;
        unique case (mode_q)
            RB_ARMED: begin
                if (meta_flag) begin          // rewind
                    mode_nx = RB_BLIND;
                    cnt_nx  = BLIND_LEN;
                end
            end
            RB_BLIND: begin
                cnt_nx = cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin    // rearm
                    mode_nx = RB_ARMED;
                end
            end
            default: begin
                mode_nx = RB_ARMED;
                cnt_nx  = '0;
            end
        endcase
    end

    always_comb begin
        rollback = (mode_q == RB_ARMED) && meta_flag;
    end

    AST_BLIND_AFTER_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> !rollback) else $error("second rewind inside blind window"); // R7
endmodule

// File: rtl/specsync_core.sv
// Handshake controller and accumulator, with rewind to the stacked state.
module specsync_core
    import specsync_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         samp,
    input  logic [W-1:0] data,
    input  logic         rollback,
    input  phase_e       rst_phase,
    input  logic [W-1:0] rst_acc,
    output phase_e       phase,
    output logic [W-1:0] acc,
    output logic         ack
);
    phase_e       phase_nx;
    logic [W-1:0] acc_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            acc   <= '0;
        end else begin
            phase <= phase_nx;
            acc   <= acc_nx;
        end
    end

    // transitions
    always_comb begin
        phase_nx = phase;
        acc_nx   = acc;
        if (rollback) begin                       // rewind
            phase_nx = rst_phase;
            acc_nx   = rst_acc;
        end else begin
            unique case (phase)
                PH_IDLE: if (samp) begin          // accept
                    phase_nx = PH_HOLD;
                    acc_nx   = acc + data;
                end
                PH_HOLD: if (!samp) begin         // release
                    phase_nx = PH_IDLE;
                end
                default: phase_nx = PH_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (phase)
            PH_HOLD: ack = 1'b1;
            default: ack = 1'b0;
        endcase
    end

    AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rollback && phase == PH_IDLE && !samp) |=> (phase == PH_IDLE && $stable(acc))) else $error("idle moved without request"); // R2
    AST_ACCEPT_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rollback && phase == PH_IDLE && samp) |=> (ack && acc == W'($past(acc) + $past(data)))) else $error("accept did not add"); // R3
    AST_HOLD_NO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rollback && phase == PH_HOLD) |=> $stable(acc)) else $error("acc moved in hold"); // R4
    AST_REWIND_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> (acc == $past(rst_acc) && phase == $past(rst_phase))) else $error("rewind lost stacked state"); // R5
endmodule

// File: rtl/specsync_rollback.sv
module specsync_rollback
    import specsync_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_async,
    input  logic [W-1:0] data_async,
    input  logic         meta_flag,
    output logic         ack,
    output logic [W-1:0] acc
);
    logic         samp;
    logic         rollback;
    phase_e       phase;
    phase_e       old_phase;
    logic [W-1:0] old_acc;

    specsync_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (req_async),
        .samp_q    (samp)
    );

    specsync_verdict #(.DEPTH(DEPTH)) u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .meta_flag (meta_flag),
        .rollback  (rollback)
    );

    specsync_history #(.W(W), .DEPTH(DEPTH)) u_history (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_phase (phase),
        .cur_acc   (acc),
        .old_phase (old_phase),
        .old_acc   (old_acc)
    );

    specsync_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp      (samp),
        .data      (data_async),
        .rollback  (rollback),
        .rst_phase (old_phase),
        .rst_acc   (old_acc),
        .phase     (phase),
        .acc       (acc),
        .ack       (ack)
    );

    AST_REWIND_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |-> meta_flag) else $error("rewind without verdict"); // R5
endmodule

// File: tb/specsync_rollback_tb.sv
`timescale 1ns/1ps
module specsync_rollback_tb;
    localparam int W = 8;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0;
    logic         flag = 1'b0;
    logic [W-1:0] data = '0;
    logic         ack;
    logic [W-1:0] acc;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [W-1:0] model = '0;

    specsync_rollback #(.W(W), .DEPTH(N)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_async  (req),
        .data_async (data),
        .meta_flag  (flag),
        .ack        (ack),
        .acc        (acc)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] add_mod(input logic [W-1:0] a, input logic [W-1:0] b);
        return W'(a + b);
    endfunction

    // one handshake; optional verdicts on the rising and falling samples
    task automatic xfer(input logic [W-1:0] d, input bit vr, input bit vf);
        int k;
        req = 1'b1; data = d;
        tick(N + 1);
        if (vr) flag = 1'b1;
        tick(1);
        flag = 1'b0;
        k = 0;
        while (ack !== 1'b1 && k < 10) begin tick(1); k++; end
        model = add_mod(model, d);
        chk("R6 ack after accept", int'(ack), 1);
        chk("R6 acc after accept", int'(acc), int'(model));
        tick(N + 2);
        chk("R4 no double add in hold", int'(acc), int'(model));
        req = 1'b0;
        tick(N + 1);
        if (vf) flag = 1'b1;
        tick(1);
        flag = 1'b0;
        tick(3);
        chk("R4 ack low after release", int'(ack), 0);
        chk("R6 acc after release", int'(acc), int'(model));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        chk("R1 ack in reset", int'(ack), 0);
        chk("R1 acc in reset", int'(acc), 0);
        rst_n = 1'b1;
        tick(2);

        // directed: latency, rewind, re-accept, masked verdict
        req = 1'b1; data = 8'd200;
        tick(1);
        chk("R2 ack still low one edge after capture", int'(ack), 0);
        tick(1);
        chk("R2 ack high after consume edge", int'(ack), 1);
        chk("R3 acc after accept", int'(acc), 200);
        tick(N - 1);
        flag = 1'b1;
        tick(1);
        flag = 1'b0;
        chk("R5 ack withdrawn by rewind", int'(ack), 0);
        chk("R5 acc restored by rewind", int'(acc), 0);
        req = 1'b0;
        tick(1);
        chk("R6 ack after re-accept", int'(ack), 1);
        chk("R6 acc after re-accept", int'(acc), 200);
        flag = 1'b1;
        tick(1);
        flag = 1'b0;
        chk("R7 masked verdict leaves ack", int'(ack), 0);
        chk("R7 masked verdict leaves acc", int'(acc), 200);
        model = 8'd200;
        tick(N + 4);

        // wrap
        xfer(8'd100, 1'b0, 1'b0);
        chk("R8 wrap 200+100", int'(acc), 44);

        // quiescent verdict
        tick(N + 4);
        flag = 1'b1;
        tick(1);
        flag = 1'b0;
        chk("R9 quiet verdict ack", int'(ack), 0);
        chk("R9 quiet verdict acc", int'(acc), int'(model));
        tick(N + 2);
        chk("R9 quiet verdict acc later", int'(acc), int'(model));

        // random handshakes with verdicts on either sample
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] d;
            bit vr, vf;
            d  = W'($urandom);
            vr = ($urandom % 3) == 0;
            vf = ($urandom % 4) == 0;
            tick(int'($urandom % 4));
            xfer(d, vr, vf);
        end
        chk("R6 final sum", int'(acc), int'(model));

        // reset must clear the stack too
        rst_n = 1'b0;
        tick(2);
        chk("R1 acc after mid reset", int'(acc), 0);
        rst_n = 1'b1;
        flag = 1'b1;
        tick(1);
        flag = 1'b0;
        chk("R1 stack cleared acc", int'(acc), 0);
        chk("R1 stack cleared ack", int'(ack), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule